// File: doc/BRIEF.md
# Packed-SIMD Integer Multiplier with Widening Modes

This unit multiplies two packed integer vectors lane by lane. It takes both operands and a 32-bit instruction word. It decodes the multiply opcode itself and returns one packed result vector. Element widths of 8, 16, 32 and 64 bits are supported. Each element width can be used in three ways:

- a truncating product that keeps the low element-width bits;
- a high product (signed or unsigned) that keeps the upper half of the double-width product;
- a widening product. It selects either the even-indexed or the odd-indexed source elements of both operands and writes full double-width products into destination elements twice as wide. The operands can be signed×signed, unsigned×unsigned, or unsigned first operand × signed second operand.

The widest widening form, 64×64→128, writes each 128-bit half of the vector on its own. The low 64 bits of the product go to the lower doubleword of that half and the high 64 bits go to the upper doubleword.

Input and output use a valid/ready handshake. An accepted operation has a one-cycle latency to a registered output stage. The output holds its value until the consumer takes it. An opcode outside the multiply space returns a zero vector with an illegal flag. The vector width is a parameter and must be a multiple of 128. At 128 the unit handles half the width in the same way.

Top module: `simd_wmul_unit`

## Requirements
- R1: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high after that same edge. `in_ready` is high exactly when the output stage is empty or `out_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, `out_result` and `out_illegal` stay constant and no new operation is accepted.
- R3: The instruction word is decoded as follows: bits 31:28 must equal 0111, bits 27:20 hold the group and bits 19:15 hold the minor code. Bits 14:0 have no effect on the result. For every group, minor bits 1:0 give the element width (0=8, 1=16, 2=32, 3=64; for widening forms this is the source width).
- R4: Group 0x48 with minor codes 8–11 gives a lane-wise product truncated to the element width.
- R5: Group 0x48 with minor codes 12–15 gives the upper half of the signed double-width product in each lane.
- R6: Group 0x48 with minor codes 16–19 gives the upper half of the unsigned double-width product in each lane.
- R7: Group 0x49 with minor codes 0–3 (even) and 4–7 (odd) gives the signed widening forms. Destination element j, which is twice the source width, holds the exact product of source elements 2j (even) or 2j+1 (odd).
- R8: Group 0x49 with minor codes 16–19 (even) and 20–23 (odd) gives the same widening forms with both operands unsigned.
- R9: Group 0x4A with minor codes 0–3 (even) and 4–7 (odd) gives the widening forms with the first operand unsigned and the second signed.
- R10: In the 64-bit-source widening forms, 128-bit half i takes source doublewords 2i+sel (sel 0 = even, 1 = odd). It writes the product's low 64 bits at doubleword 2i and its high 64 bits at doubleword 2i+1.
- R11: Any other instruction word gives `out_illegal` high and an all-zero `out_result`.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_insn | input | 32 | Instruction word |
| in_src_a | input | VLEN | First operand vector |
| in_src_b | input | VLEN | Second operand vector |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | VLEN | Packed result vector |
| out_illegal | output | 1 | Opcode outside the multiply space |

## Verification
The bench builds the unit with the default 256-bit width. At that width every element size has at least four lanes, and the 64→128 forms must fill two separate 128-bit halves. This exposes any swap of halves or of even/odd selection. Random opcodes cover the legal multiply space and near-miss codes, and the register fields are randomised throughout. Directed vectors use the most-negative value squared and all-ones operands, and their expected values are worked out by hand. A stall sequence holds the output while a second operation waits at the input.

// File: rtl/simd_wmul_pkg.sv
package simd_wmul_pkg;

  typedef enum logic [1:0] {
    KIND_LO   = 2'd0,
    KIND_HI   = 2'd1,
    KIND_WIDE = 2'd2,
    KIND_NONE = 2'd3
  } mul_kind_e;

  typedef struct packed {
    mul_kind_e  kind;
    logic [1:0] size_log;
    logic       a_signed;
    logic       b_signed;
    logic       pick_odd;
    logic       illegal;
  } mul_ctrl_t;

  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned MIN_ES    = 8;

  localparam logic [3:0] OP_PREFIX = 4'b0111;
  localparam logic [7:0] GRP_LANE  = 8'h48;
  localparam logic [7:0] GRP_WIDE  = 8'h49;
  localparam logic [7:0] GRP_MIXED = 8'h4A;

endpackage

// File: rtl/simd_wmul_decode.sv
module simd_wmul_decode
  import simd_wmul_pkg::*;
(
  input  logic [16:0] op_field,
  output mul_ctrl_t   ctrl
);

  logic [3:0] prefix;
  logic [7:0] group;
  logic [4:0] minor;

  assign prefix = op_field[16:13];
  assign group  = op_field[12:5];
  assign minor  = op_field[4:0];

  always_comb begin
    ctrl          = '0;
    ctrl.kind     = KIND_NONE;
    ctrl.illegal  = 1'b1;
    ctrl.size_log = minor[1:0];
    ctrl.pick_odd = minor[2];
    if (prefix == OP_PREFIX) begin
      unique case (group)
        GRP_LANE: begin
          unique case (minor[4:2])
            3'b010: begin
              ctrl.kind = KIND_LO; ctrl.a_signed = 1'b1; ctrl.b_signed = 1'b1;
              ctrl.illegal = 1'b0;
            end
            3'b011: begin
              ctrl.kind = KIND_HI; ctrl.a_signed = 1'b1; ctrl.b_signed = 1'b1;
              ctrl.illegal = 1'b0;
            end
            3'b100: begin
              ctrl.kind = KIND_HI; ctrl.illegal = 1'b0;
            end
            default: ;
          endcase
        end
        GRP_WIDE: begin
          if (minor[4:3] == 2'b00) begin
            ctrl.kind = KIND_WIDE; ctrl.a_signed = 1'b1; ctrl.b_signed = 1'b1;
            ctrl.illegal = 1'b0;
          end else if (minor[4:3] == 2'b10) begin
            ctrl.kind = KIND_WIDE; ctrl.illegal = 1'b0;
          end
        end
        GRP_MIXED: begin
          if (minor[4:3] == 2'b00) begin
            ctrl.kind = KIND_WIDE; ctrl.b_signed = 1'b1; ctrl.illegal = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/simd_wmul_slice.sv
module simd_wmul_slice #(
  parameter int unsigned VLEN = 256,
  parameter int unsigned ES   = 8
) (
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  input  logic            a_signed,
  input  logic            b_signed,
  input  logic            pick_odd,
  output logic [VLEN-1:0] res_lo,
  output logic [VLEN-1:0] res_hi,
  output logic [VLEN-1:0] res_wide
);

  localparam int unsigned NL = VLEN / ES;
  localparam int unsigned PW = 2 * ES;
  localparam int unsigned ND = NL / 2;

  logic [NL-1:0][PW-1:0] prod;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [ES-1:0] a_el, b_el;
    logic          a_ext, b_ext;
    logic [PW-1:0] a_wide, b_wide;

    assign a_el   = src_a[g*ES +: ES];
    assign b_el   = src_b[g*ES +: ES];
    assign a_ext  = a_signed & a_el[ES-1];
    assign b_ext  = b_signed & b_el[ES-1];
    assign a_wide = {{ES{a_ext}}, a_el};
    assign b_wide = {{ES{b_ext}}, b_el};
    // exact product of ES-bit operands always fits in PW bits
    assign prod[g] = a_wide * b_wide;

    assign res_lo[g*ES +: ES] = prod[g][ES-1:0];
    assign res_hi[g*ES +: ES] = prod[g][PW-1:ES];
  end

  for (genvar j = 0; j < ND; j++) begin : g_dest
    assign res_wide[j*PW +: PW] = pick_odd ? prod[2*j+1] : prod[2*j];
  end

endmodule

// File: rtl/simd_wmul_core.sv
module simd_wmul_core
  import simd_wmul_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  input  mul_ctrl_t       ctrl,
  output logic [VLEN-1:0] result
);

  logic [NUM_SIZES-1:0][VLEN-1:0] lo_by_size;
  logic [NUM_SIZES-1:0][VLEN-1:0] hi_by_size;
  logic [NUM_SIZES-1:0][VLEN-1:0] wide_by_size;

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    simd_wmul_slice #(
      .VLEN (VLEN),
      .ES   (MIN_ES << k)
    ) u_slice (
      .src_a    (src_a),
      .src_b    (src_b),
      .a_signed (ctrl.a_signed),
      .b_signed (ctrl.b_signed),
      .pick_odd (ctrl.pick_odd),
      .res_lo   (lo_by_size[k]),
      .res_hi   (hi_by_size[k]),
      .res_wide (wide_by_size[k])
    );
  end

  always_comb begin
    result = '0;
    if (!ctrl.illegal) begin
      unique case (ctrl.kind)
        KIND_LO:   result = lo_by_size[ctrl.size_log];
        KIND_HI:   result = hi_by_size[ctrl.size_log];
        KIND_WIDE: result = wide_by_size[ctrl.size_log];
        default:   result = '0;
      endcase
    end
  end

endmodule

// File: rtl/simd_wmul_unit.sv
module simd_wmul_unit
  import simd_wmul_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_insn,
  input  logic [VLEN-1:0] in_src_a,
  input  logic [VLEN-1:0] in_src_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VLEN-1:0] out_result,
  output logic            out_illegal
);

  mul_ctrl_t       ctrl;
  logic [VLEN-1:0] core_result;
  logic            accept;
  logic            valid_nxt;
  logic [VLEN-1:0] result_nxt;
  logic            illegal_nxt;
  logic            unused_reg_fields;

  // register-number fields do not take part in the operation
  assign unused_reg_fields = ^in_insn[14:0];

  simd_wmul_decode u_decode (
    .op_field (in_insn[31:15]),
    .ctrl     (ctrl)
  );

  simd_wmul_core #(
    .VLEN (VLEN)
  ) u_core (
    .src_a  (in_src_a),
    .src_b  (in_src_b),
    .ctrl   (ctrl),
    .result (core_result)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    valid_nxt   = out_valid;
    result_nxt  = out_result;
    illegal_nxt = out_illegal;
    if (accept) begin
      valid_nxt   = 1'b1;
      result_nxt  = core_result;
      illegal_nxt = ctrl.illegal;
    end else if (out_ready) begin
      valid_nxt   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= valid_nxt;
      if (accept) begin
        out_result  <= result_nxt;
        out_illegal <= illegal_nxt;
      end
    end
  end

endmodule

// File: rtl/simd_wmul_unit_chk.sv
module simd_wmul_unit_chk #(
  parameter int unsigned VLEN = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [VLEN-1:0] out_result,
  input logic            out_illegal
);

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R1

  AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R1

  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R1

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_illegal)); // R2

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_result == '0); // R11

endmodule

bind simd_wmul_unit simd_wmul_unit_chk #(.VLEN(VLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/test_simd_wmul_unit.sv
`timescale 1ns/1ps
module test_simd_wmul_unit;

  localparam int VL = 256;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [31:0]   in_insn;
  logic [VL-1:0] in_src_a;
  logic [VL-1:0] in_src_b;
  logic          out_valid;
  logic          out_ready;
  logic [VL-1:0] out_result;
  logic          out_illegal;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  simd_wmul_unit #(.VLEN(VL)) i_simd_wmul_unit (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready), .in_insn (in_insn),
    .in_src_a (in_src_a), .in_src_b (in_src_b),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_result (out_result), .out_illegal (out_illegal)
  );

  function automatic logic [31:0] mk(input logic [7:0] grp, input logic [4:0] mnr);
    return {4'b0111, grp, mnr, 15'($urandom)};
  endfunction

  function automatic logic [127:0] widen(input logic [VL-1:0] v, input int idx,
                                         input int es, input bit sg);
    logic [127:0] r = '0;
    for (int k = 0; k < es; k++) r[k] = v[idx*es+k];
    if (sg && v[idx*es+es-1]) for (int k = es; k < 128; k++) r[k] = 1'b1;
    return r;
  endfunction

  task automatic model(input logic [31:0] insn, input logic [VL-1:0] a, b,
                       output logic [VL-1:0] res, output bit ill, output string tag);
    int  grp = int'(insn[27:20]);
    int  mnr = int'(insn[19:15]);
    int  es  = 8 << insn[16:15];
    int  mode = 0; // 0 none, 1 low, 2 high, 3 widen
    bit  sa = 0, sb = 0, odd = insn[17];
    logic [127:0] p;
    res = '0; ill = 1'b1; tag = "R11";
    if (insn[31:28] == 4'b0111) begin
      if (grp == 'h48 && mnr >= 8 && mnr <= 11) begin mode = 1; sa = 1; sb = 1; tag = "R4"; end
      else if (grp == 'h48 && mnr >= 12 && mnr <= 15) begin mode = 2; sa = 1; sb = 1; tag = "R5"; end
      else if (grp == 'h48 && mnr >= 16 && mnr <= 19) begin mode = 2; tag = "R6"; end
      else if (grp == 'h49 && mnr <= 7) begin mode = 3; sa = 1; sb = 1; tag = "R7"; end
      else if (grp == 'h49 && mnr >= 16 && mnr <= 23) begin mode = 3; tag = "R8"; end
      else if (grp == 'h4A && mnr <= 7) begin mode = 3; sb = 1; tag = "R9"; end
    end
    if (mode == 3 && es == 64) tag = "R10";
    if (mode != 0) ill = 1'b0;
    if (mode == 1 || mode == 2) begin
      for (int i = 0; i < VL/es; i++) begin
        p = widen(a, i, es, sa) * widen(b, i, es, sb);
        for (int k = 0; k < es; k++) res[i*es+k] = (mode == 1) ? p[k] : p[es+k];
      end
    end else if (mode == 3) begin
      for (int j = 0; j < VL/(2*es); j++) begin
        p = widen(a, 2*j + int'(odd), es, sa) * widen(b, 2*j + int'(odd), es, sb);
        for (int k = 0; k < 2*es; k++) res[j*2*es+k] = p[k];
      end
    end
  endtask

  task automatic check(input string tag, input logic [VL-1:0] got, exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check1(input string tag, input logic got, exp);
    check(tag, {{(VL-1){1'b0}}, got}, {{(VL-1){1'b0}}, exp});
  endtask

  // one operation, consumer always ready; sample one cycle after acceptance
  task automatic run_op(input logic [31:0] insn, input logic [VL-1:0] a, b,
                        input bit use_hand, input logic [VL-1:0] hand, input string htag);
    logic [VL-1:0] er;
    bit ei;
    string tg;
    model(insn, a, b, er, ei, tg);
    @(negedge clk);
    in_valid = 1'b1; in_insn = insn; in_src_a = a; in_src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check1("R1", out_valid, 1'b1);
    check(tg, out_result, er);
    check1({tg, "_flag"}, out_illegal, ei);
    if (use_hand) check(htag, out_result, hand);
  endtask

  function automatic logic [VL-1:0] rnd_vec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [31:0] rnd_insn();
    int r = int'($urandom % 48);
    if (r < 12) return mk(8'h48, 5'(8 + r));
    if (r < 28) return mk(8'h49, (r - 12 < 8) ? 5'(r - 12) : 5'(r - 12 + 8));
    if (r < 36) return mk(8'h4A, 5'(r - 28));
    if (r < 40) return mk(8'h48, 5'($urandom % 8));
    if (r < 44) return mk(8'h4B, 5'($urandom));
    return $urandom;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [VL-1:0] e1, e2, held, a1, b1, a2, b2;
    logic [31:0]   op1, op2;
    bit ei;
    string tg;
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_insn = '0; in_src_a = '0; in_src_b = '0;
    repeat (3) @(negedge clk);
    check1("R12", out_valid, 1'b0);
    check1("R12", in_ready, 1'b1);
    rst_n = 1'b1;

    // directed corner cases, hand-computed
    run_op(mk(8'h48, 5'd12), {32{8'h80}}, {32{8'h80}}, 1, {32{8'h40}}, "R5");
    run_op(mk(8'h48, 5'd8),  {32{8'h80}}, {32{8'h80}}, 1, '0, "R4");
    run_op(mk(8'h48, 5'd16), {32{8'hFF}}, {32{8'hFF}}, 1, {32{8'hFE}}, "R6");
    run_op(mk(8'h48, 5'd12), {32{8'hFF}}, {32{8'hFF}}, 1, '0, "R5");
    run_op(mk(8'h48, 5'd11), {VL{1'b1}}, {VL{1'b1}}, 1, {4{64'h1}}, "R4");
    run_op(mk(8'h4A, 5'd0),  {VL{1'b1}}, {VL{1'b1}}, 1, {16{16'hFF01}}, "R9");
    run_op(mk(8'h49, 5'd16), {VL{1'b1}}, {VL{1'b1}}, 1, {16{16'hFE01}}, "R8");
    run_op(mk(8'h49, 5'd3),  {4{64'h8000_0000_0000_0000}}, {4{64'h8000_0000_0000_0000}},
           1, {2{64'h4000_0000_0000_0000, 64'h0}}, "R10");
    run_op(mk(8'h49, 5'd7),  {64'd3, 64'd0, 64'd5, 64'd0}, {64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd7, 64'd0},
           1, {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFD, 64'd0, 64'd35}, "R10");
    run_op(mk(8'h49, 5'd4),  {{30{8'h00}}, 8'h02, 8'h7F}, {{30{8'h00}}, 8'hFD, 8'h01},
           1, {{15{16'h0}}, 16'hFFFA}, "R7");
    run_op({4'b0110, 8'h48, 5'd8, 15'd0}, {VL{1'b1}}, {VL{1'b1}}, 1, '0, "R11");
    run_op(mk(8'h48, 5'd20), {VL{1'b1}}, {VL{1'b1}}, 1, '0, "R11");
    // register fields ignored: same operation, different fields
    a1 = rnd_vec(); b1 = rnd_vec();
    run_op({4'b0111, 8'h49, 5'd1, 15'h0000}, a1, b1, 0, '0, "R3");
    held = out_result;
    run_op({4'b0111, 8'h49, 5'd1, 15'h7FFF}, a1, b1, 1, held, "R3");

    // random mix
    for (int n = 0; n < 400; n++) run_op(rnd_insn(), rnd_vec(), rnd_vec(), 0, '0, "");

    // stall: output held, second op waits
    op1 = mk(8'h48, 5'd13); a1 = rnd_vec(); b1 = rnd_vec();
    op2 = mk(8'h4A, 5'd6);  a2 = rnd_vec(); b2 = rnd_vec();
    model(op1, a1, b1, e1, ei, tg);
    model(op2, a2, b2, e2, ei, tg);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_insn = op1; in_src_a = a1; in_src_b = b1;
    @(negedge clk);
    in_insn = op2; in_src_a = a2; in_src_b = b2;
    check1("R1", out_valid, 1'b1);
    check1("R2", in_ready, 1'b0);
    check("R5", out_result, e1);
    repeat (2) begin
      @(negedge clk);
      check1("R2", out_valid, 1'b1);
      check("R2", out_result, e1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check1("R1", out_valid, 1'b1);
    check("R9", out_result, e2);
    @(negedge clk);
    check1("R1", out_valid, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule